// File: doc/BRIEF.md
# Data Address Generation Unit

This unit forms the data-space address for every memory-touching operation of a small 8-bit microcontroller core: loads and stores through the three pointer registers, absolute and I/O-space accesses, and the stack traffic of push, pop, call and return. From the same inputs it also produces the updated pointer or stack-pointer value that the register file must store once the access is done.

The decoder supplies a 4-bit mode code, the current values of the X, Y and Z pointers and the stack pointer, a 6-bit displacement, a 6-bit I/O register number and the second instruction word as an absolute address. It also supplies two flags: whether the operation is a load, and whether this is its first execution cycle. The effective address is purely combinational. The write-back enable, the target select and the new value are registered, so they appear one cycle after the inputs that caused them.

Top module: `dagu_top`

## Requirements
- R1: Mode 0 (absolute) drives the address from the absolute input. Mode 1 (I/O) drives the zero-extended I/O number plus 0x20.
- R2: Mode 2 (X indirect) drives the address from X, and mode 3 (Z indirect) drives it from Z.
- R3: Modes 4, 5 and 6 (post-increment of X, Y and Z) drive the old pointer as the address and write back the pointer plus one.
- R4: Modes 7, 8 and 9 (pre-decrement of X, Y and Z) drive the pointer minus one as the address and write back that same value.
- R5: Modes 10 and 11 drive Y or Z plus the zero-extended displacement, with no write-back. A displacement of zero yields the plain pointer.
- R6: Mode 12 (one-byte push) addresses SP and writes back SP-1. Mode 13 (two-byte push) addresses SP-1 and writes back SP-2.
- R7: Mode 14 (one-byte pop) addresses SP+1 and writes back SP+1. Mode 15 (two-byte pop) addresses SP+1 and writes back SP+2.
- R8: Modes 0, 1, 2, 3, 10 and 11 never raise the write-back enable.
- R9: When the load flag and the first-cycle flag are both high, the write-back enable stays low for every mode.
- R10: The write-back enable, select and value are registered and appear one clock after their inputs. The select codes are X=0, Y=1, Z=2 and SP=3. Reset clears the enable, the select and the value.
- R11: All address and write-back arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Addressing mode code |
| isLoad | input | 1 | Operation is a load |
| firstCycle | input | 1 | First execution cycle of the operation |
| ptrX | input | ADDR_W | X pointer |
| ptrY | input | ADDR_W | Y pointer |
| ptrZ | input | ADDR_W | Z pointer |
| sp | input | ADDR_W | Stack pointer |
| disp | input | DISP_W | Displacement for modes 10/11 |
| ioNum | input | IO_W | I/O register number |
| absAddr | input | ADDR_W | Absolute address (second instruction word) |
| addr | output | ADDR_W | Effective data address |
| wbEn | output | 1 | Registered write-back enable |
| wbSel | output | 2 | Registered write-back target |
| wbData | output | ADDR_W | Registered write-back value |

## Verification
The bench builds the unit with ADDR_W set to 8, keeping the default 6-bit displacement and I/O number. With that width, every pointer value from 0x00 to 0xFF can be swept for all sixteen modes and all four load/first-cycle combinations. This drives the wrap at both ends of the space through each increment, decrement, displacement and stack adjustment, and takes the displacement through zero and its full range.

// File: rtl/dagu_pkg.sv
package dagu_pkg;

  typedef enum logic [3:0] {
    MODE_ABS   = 4'd0,
    MODE_IO    = 4'd1,
    MODE_X     = 4'd2,
    MODE_Z     = 4'd3,
    MODE_XINC  = 4'd4,
    MODE_YINC  = 4'd5,
    MODE_ZINC  = 4'd6,
    MODE_XDEC  = 4'd7,
    MODE_YDEC  = 4'd8,
    MODE_ZDEC  = 4'd9,
    MODE_YDISP = 4'd10,
    MODE_ZDISP = 4'd11,
    MODE_PUSH1 = 4'd12,
    MODE_PUSH2 = 4'd13,
    MODE_POP1  = 4'd14,
    MODE_POP2  = 4'd15
  } aguMode_e;

  localparam logic [1:0] SEL_X  = 2'd0;
  localparam logic [1:0] SEL_Y  = 2'd1;
  localparam logic [1:0] SEL_Z  = 2'd2;
  localparam logic [1:0] SEL_SP = 2'd3;

  // Strobes from control to datapath; offsets are 3-bit two's complement.
  typedef struct packed {
    logic [1:0] baseSel;
    logic       useAbs;
    logic       useIo;
    logic       useDisp;
    logic [2:0] addrOff;
    logic [2:0] wbOff;
    logic       wbCapable;
  } aguCtl_t;

endpackage

// File: rtl/dagu_ctrl.sv
module dagu_ctrl
  import dagu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    mode,
  input  logic          isLoad,
  input  logic          firstCycle,
  output aguCtl_t       ctl,
  output logic          wbEn
);

  aguMode_e modeE;
  assign modeE = aguMode_e'(mode);

  always_comb begin
    ctl = '{baseSel: SEL_X, useAbs: 1'b0, useIo: 1'b0, useDisp: 1'b0,
            addrOff: 3'd0, wbOff: 3'd0, wbCapable: 1'b0};
    case (modeE)
      MODE_ABS:   ctl.useAbs = 1'b1;
      MODE_IO:    ctl.useIo = 1'b1;
      MODE_X:     ctl.baseSel = SEL_X;
      MODE_Z:     ctl.baseSel = SEL_Z;
      MODE_XINC:  begin ctl.baseSel = SEL_X; ctl.wbOff = 3'd1; ctl.wbCapable = 1'b1; end
      MODE_YINC:  begin ctl.baseSel = SEL_Y; ctl.wbOff = 3'd1; ctl.wbCapable = 1'b1; end
      MODE_ZINC:  begin ctl.baseSel = SEL_Z; ctl.wbOff = 3'd1; ctl.wbCapable = 1'b1; end
      MODE_XDEC:  begin ctl.baseSel = SEL_X; ctl.addrOff = 3'b111; ctl.wbOff = 3'b111; ctl.wbCapable = 1'b1; end
      MODE_YDEC:  begin ctl.baseSel = SEL_Y; ctl.addrOff = 3'b111; ctl.wbOff = 3'b111; ctl.wbCapable = 1'b1; end
      MODE_ZDEC:  begin ctl.baseSel = SEL_Z; ctl.addrOff = 3'b111; ctl.wbOff = 3'b111; ctl.wbCapable = 1'b1; end
      MODE_YDISP: begin ctl.baseSel = SEL_Y; ctl.useDisp = 1'b1; end
      MODE_ZDISP: begin ctl.baseSel = SEL_Z; ctl.useDisp = 1'b1; end
      MODE_PUSH1: begin ctl.baseSel = SEL_SP; ctl.wbOff = 3'b111; ctl.wbCapable = 1'b1; end
      MODE_PUSH2: begin ctl.baseSel = SEL_SP; ctl.addrOff = 3'b111; ctl.wbOff = 3'b110; ctl.wbCapable = 1'b1; end
      MODE_POP1:  begin ctl.baseSel = SEL_SP; ctl.addrOff = 3'd1; ctl.wbOff = 3'd1; ctl.wbCapable = 1'b1; end
      MODE_POP2:  begin ctl.baseSel = SEL_SP; ctl.addrOff = 3'd1; ctl.wbOff = 3'd2; ctl.wbCapable = 1'b1; end
      default:    ctl.useAbs = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wbEn <= 1'b0;
    else       wbEn <= ctl.wbCapable && !(isLoad && firstCycle);
  end

  // R9
  load_first_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && firstCycle) |=> !wbEn);

  // R8
  plain_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode <= 4'd3 || mode == 4'd10 || mode == 4'd11) |=> !wbEn);

endmodule

// File: rtl/dagu_dpath.sv
module dagu_dpath
  import dagu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int IO_BASE = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtl_t           ctl,
  input  logic [ADDR_W-1:0] ptrX,
  input  logic [ADDR_W-1:0] ptrY,
  input  logic [ADDR_W-1:0] ptrZ,
  input  logic [ADDR_W-1:0] sp,
  input  logic [DISP_W-1:0] disp,
  input  logic [IO_W-1:0]   ioNum,
  input  logic [ADDR_W-1:0] absAddr,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        wbSel,
  output logic [ADDR_W-1:0] wbData
);

  localparam logic [ADDR_W-1:0] IO_BASE_V = ADDR_W'(IO_BASE);

  logic [ADDR_W-1:0] basePtr;
  logic [ADDR_W-1:0] addrOffExt;
  logic [ADDR_W-1:0] wbOffExt;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] ioAddr;
  logic [ADDR_W-1:0] nextVal;

  always_comb begin
    case (ctl.baseSel)
      SEL_X:   basePtr = ptrX;
      SEL_Y:   basePtr = ptrY;
      SEL_Z:   basePtr = ptrZ;
      default: basePtr = sp;
    endcase
  end

  assign addrOffExt = {{(ADDR_W-3){ctl.addrOff[2]}}, ctl.addrOff};
  assign wbOffExt   = {{(ADDR_W-3){ctl.wbOff[2]}}, ctl.wbOff};
  assign dispExt    = {{(ADDR_W-DISP_W){1'b0}}, disp};
  assign ioAddr     = {{(ADDR_W-IO_W){1'b0}}, ioNum} + IO_BASE_V;
  assign nextVal    = basePtr + wbOffExt;

  always_comb begin
    if (ctl.useAbs)      addr = absAddr;
    else if (ctl.useIo)  addr = ioAddr;
    else if (ctl.useDisp) addr = basePtr + dispExt;
    else                 addr = basePtr + addrOffExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbSel  <= SEL_X;
      wbData <= '0;
    end else begin
      wbSel  <= ctl.baseSel;
      wbData <= nextVal;
    end
  end

  // R5
  disp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useDisp && !ctl.useAbs && !ctl.useIo) |-> ((addr - basePtr) < ADDR_W'(1 << DISP_W)));

endmodule

// File: rtl/dagu_top.sv
module dagu_top #(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int IO_BASE = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        mode,
  input  logic              isLoad,
  input  logic              firstCycle,
  input  logic [ADDR_W-1:0] ptrX,
  input  logic [ADDR_W-1:0] ptrY,
  input  logic [ADDR_W-1:0] ptrZ,
  input  logic [ADDR_W-1:0] sp,
  input  logic [DISP_W-1:0] disp,
  input  logic [IO_W-1:0]   ioNum,
  input  logic [ADDR_W-1:0] absAddr,
  output logic [ADDR_W-1:0] addr,
  output logic              wbEn,
  output logic [1:0]        wbSel,
  output logic [ADDR_W-1:0] wbData
);

  dagu_pkg::aguCtl_t ctl;

  dagu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .isLoad(isLoad),
    .firstCycle(firstCycle), .ctl(ctl), .wbEn(wbEn)
  );

  dagu_dpath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IO_W(IO_W), .IO_BASE(IO_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ),
    .sp(sp), .disp(disp), .ioNum(ioNum), .absAddr(absAddr),
    .addr(addr), .wbSel(wbSel), .wbData(wbData)
  );

  // R4
  predec_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd9) |-> (addr == ptrZ - ADDR_W'(1)));

  // R3
  postinc_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd4 && !isLoad) |=> (wbEn && wbSel == 2'd0 && wbData == $past(ptrX) + ADDR_W'(1)));

  // R6
  stack_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode >= 4'd12 && !(isLoad && firstCycle)) |=> (wbEn && wbSel == 2'd3));

  // R2
  plain_x_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd2) |-> (addr == ptrX));

endmodule

// File: tb/dagu_top_bench.sv
`timescale 1ns/1ps
module dagu_top_bench;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    mode = '0;
  logic          isLoad = 1'b0;
  logic          firstCycle = 1'b0;
  logic [AW-1:0] ptrX = '0, ptrY = '0, ptrZ = '0, sp = '0, absAddr = '0;
  logic [5:0]    disp = '0, ioNum = '0;
  logic [AW-1:0] addr, wbData;
  logic          wbEn;
  logic [1:0]    wbSel;

  int nTests = 0;
  int nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dagu_top #(.ADDR_W(AW)) u_dagu_top (
    .clk(clk), .rstN(rstN), .mode(mode), .isLoad(isLoad), .firstCycle(firstCycle),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ), .sp(sp), .disp(disp), .ioNum(ioNum),
    .absAddr(absAddr), .addr(addr), .wbEn(wbEn), .wbSel(wbSel), .wbData(wbData)
  );

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: mode=%0d x=%0h y=%0h z=%0h sp=%0h actual=%0h expected=%0h",
               req, mode, ptrX, ptrY, ptrZ, sp, act, exp);
    end
  endtask

  function automatic string reqOf(int m);
    case (m)
      0, 1:     return "R1";
      2, 3:     return "R2";
      4, 5, 6:  return "R3";
      7, 8, 9:  return "R4";
      10, 11:   return "R5";
      12, 13:   return "R6";
      default:  return "R7";
    endcase
  endfunction

  initial begin
    #100000000;
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", int'(wbEn), 0);
    check("R10", int'(wbSel), 0);
    check("R10", int'(wbData), 0);
    rstN = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 256; v++) begin
        for (int lf = 0; lf < 4; lf++) begin
          int base, expAddr, expWb, expSel, expEn, capable;
          @(negedge clk);
          mode = 4'(m);
          isLoad = lf[1];
          firstCycle = lf[0];
          ptrX = 8'(v);
          ptrY = 8'(v ^ 8'h5A);
          ptrZ = 8'(v + 8'h33);
          sp = 8'(v + 8'hA5);
          disp = 6'((v * 7) + lf);
          ioNum = 6'(v);
          absAddr = 8'(~v);
          case (m)
            2, 4, 7:      begin base = int'(ptrX); expSel = 0; end
            5, 8, 10:     begin base = int'(ptrY); expSel = 1; end
            3, 6, 9, 11:  begin base = int'(ptrZ); expSel = 2; end
            default:      begin base = int'(sp);   expSel = 3; end
          endcase
          case (m)
            0:  expAddr = int'(absAddr);
            1:  expAddr = int'(ioNum) + 32;
            2, 3, 4, 5, 6, 12: expAddr = base;
            7, 8, 9, 13: expAddr = base - 1;
            10, 11: expAddr = base + int'(disp);
            default: expAddr = base + 1;
          endcase
          case (m)
            4, 5, 6, 14: expWb = base + 1;
            7, 8, 9, 12: expWb = base - 1;
            13: expWb = base - 2;
            15: expWb = base + 2;
            default: expWb = base;
          endcase
          expAddr = expAddr & 8'hFF;  // R11 wrap
          expWb = expWb & 8'hFF;
          capable = (m >= 4 && m <= 9) || m >= 12;
          expEn = capable && !(lf == 3);
          #2;
          check(reqOf(m), int'(addr), expAddr);
          @(posedge clk);
          #2;
          if (!capable) check("R8", int'(wbEn), 0);
          else if (lf == 3) check("R9", int'(wbEn), 0);
          else begin
            check("R10", int'(wbEn), expEn);
            check(reqOf(m), int'(wbSel), expSel);
            check(m >= 12 ? reqOf(m) : "R11", int'(wbData), expWb);
          end
        end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule